// File: doc/BRIEF.md
# Core Timer Flag Register

This block is a free-running binary counter with one 8-bit control and status register on a simple synchronous register bus. The counter advances once per clock. Two sticky event flags live in the register. The wrap flag latches each time the low byte of the counter rolls over. The tap flag latches on the rising edge of one of four upper counter bits, and a two-bit rate field picks which bit.

Each flag has an enable bit. Each interrupt request output is the flag ANDed with its enable. Software cannot write a flag directly. It clears a flag by writing 1 to a separate clear bit, and the clear bits always read as 0. If a set event and a clear write fall in the same cycle, the set is kept, so no event is lost.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `ctmr_core`

## Requirements
- R1: The register is at address 0x08. Its bits, from bit 7 down to bit 0, are: wrap flag, tap flag, wrap enable, tap enable, wrap clear, tap clear, rate[1], rate[0].
- R2: The wrap flag sets on the clock edge where counter bits [7:0] go from 0xFF to 0x00, which is once every 256 clocks.
- R3: The tap flag sets on the clock edge where counter bit 11+rate goes from 0 to 1. Rate 0 selects bit 11, rate 1 bit 12, rate 2 bit 13 and rate 3 bit 14.
- R4: irq_ovf equals wrap flag AND wrap enable, and irq_rt equals tap flag AND tap enable. Both are combinational, with no added cycle.
- R5: A write with bit 3 set clears the wrap flag, and a write with bit 2 set clears the tap flag. Clearing one flag leaves the other unchanged. Writing 1 or 0 to bits 7 and 6 has no effect on the flags.
- R6: Bits 3 and 2 always read as 0.
- R7: During reset and just after it, the register reads 0x03 and both interrupt requests are 0.
- R8: If a flag's set event and its clear write fall on the same clock edge, the flag ends up set.
- R9: A read at any address other than 0x08 returns 0x00. A write to any other address leaves the register unchanged.
- R10: A write to the register stores the enables (bits 5 and 4) and the rate (bits 1:0), and they read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_ovf | output | 1 | Wrap interrupt request |
| irq_rt | output | 1 | Tap interrupt request |

## Verification
The bench first locks a reference counter to the first wrap event. It then checks the wrap flag one clock before and on the predicted wrap edge. Each of the four rate values is tried against the reference: the tap flag must still be clear one clock before its own bit rises and set just after. This separates a correct tap from a neighbouring bit that rises earlier or later. Register writes are tried with flag-position bits only, with one clear bit at a time, at a foreign address, and on the exact wrap edge. These patterns separate "no effect" from "clear", one flag from the other, and set-wins from clear-wins.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned RATE_W   = 2;
  localparam int unsigned NUM_TAPS = 1 << RATE_W;
  localparam int unsigned TAP_BASE = 11;
  localparam int unsigned LOW_W    = 8;

  // bit positions inside the control/status word
  localparam int unsigned BIT_OVF_F   = 7;
  localparam int unsigned BIT_RT_F    = 6;
  localparam int unsigned BIT_OVF_EN  = 5;
  localparam int unsigned BIT_RT_EN   = 4;
  localparam int unsigned BIT_OVF_CLR = 3;
  localparam int unsigned BIT_RT_CLR  = 2;
  localparam int unsigned RATE_LSB    = 0;

  typedef struct packed {
    logic              ovf_f;
    logic              rt_f;
    logic              ovf_en;
    logic              rt_en;
    logic [RATE_W-1:0] rate;
  } ctl_state_t;
endpackage

// File: rtl/ctmr_rst_sync.sv
module ctmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
  parameter int unsigned CNT_W    = 15,
  parameter int unsigned LOW_W    = 8,
  parameter int unsigned TAP_BASE = 11,
  parameter int unsigned NUM_TAPS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                wrap_evt,
  output logic [NUM_TAPS-1:0] tap_evt
);
  localparam int unsigned TOP_TAP = TAP_BASE + NUM_TAPS - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // the counter runs on every clock; the enable is kept explicit
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // the next edge wraps the low stages when they are all ones
  assign wrap_evt = &cnt_q[LOW_W-1:0];

  // the next edge raises tap bit B when bits below it are ones and B is 0
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int unsigned B = TAP_BASE + i;
    assign tap_evt[i] = (&cnt_q[B-1:0]) & ~cnt_q[B];
  end

  if (TOP_TAP >= CNT_W) begin : g_bad_width
    initial $error("counter too narrow for the highest tap");
  end
endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                wrap_evt,
  input  logic [NUM_TAPS-1:0] tap_evt,
  output logic [DATA_W-1:0]   reg_word,
  output logic                ovf_flag,
  output logic                rt_flag,
  output logic                ovf_en,
  output logic                rt_en,
  output logic                rt_evt
);
  ctl_state_t state_q;
  ctl_state_t state_d;
  logic       clr_ovf;
  logic       clr_rt;

  assign rt_evt  = tap_evt[state_q.rate];
  assign clr_ovf = wr_hit & wdata[BIT_OVF_CLR];
  assign clr_rt  = wr_hit & wdata[BIT_RT_CLR];

  always_comb begin
    state_d = state_q;
    if (wr_hit) begin
      state_d.ovf_en = wdata[BIT_OVF_EN];
      state_d.rt_en  = wdata[BIT_RT_EN];
      state_d.rate   = wdata[RATE_LSB +: RATE_W];
    end
    // set has priority over clear
    state_d.ovf_f = wrap_evt | (state_q.ovf_f & ~clr_ovf);
    state_d.rt_f  = rt_evt   | (state_q.rt_f  & ~clr_rt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q.ovf_f  <= 1'b0;
      state_q.rt_f   <= 1'b0;
      state_q.ovf_en <= 1'b0;
      state_q.rt_en  <= 1'b0;
      state_q.rate   <= '1;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    reg_word                        = '0;
    reg_word[BIT_OVF_F]             = state_q.ovf_f;
    reg_word[BIT_RT_F]              = state_q.rt_f;
    reg_word[BIT_OVF_EN]            = state_q.ovf_en;
    reg_word[BIT_RT_EN]             = state_q.rt_en;
    reg_word[RATE_LSB +: RATE_W]    = state_q.rate;
  end

  assign ovf_flag = state_q.ovf_f;
  assign rt_flag  = state_q.rt_f;
  assign ovf_en   = state_q.ovf_en;
  assign rt_en    = state_q.rt_en;
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int unsigned     CNT_W    = 15,
  parameter int unsigned     ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_ovf,
  output logic              irq_rt
);
  logic                rst_sync_n;
  logic                wrap_evt;
  logic [NUM_TAPS-1:0] tap_evt;
  logic                rt_evt;
  logic                rd_hit;
  logic                wr_hit;
  logic [DATA_W-1:0]   reg_word;
  logic                ovf_flag;
  logic                rt_flag;
  logic                ovf_en;
  logic                rt_en;

  ctmr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  ctmr_counter #(
    .CNT_W    (CNT_W),
    .LOW_W    (LOW_W),
    .TAP_BASE (TAP_BASE),
    .NUM_TAPS (NUM_TAPS)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wrap_evt (wrap_evt),
    .tap_evt  (tap_evt)
  );

  assign rd_hit = (bus_addr == REG_ADDR);
  assign wr_hit = bus_wr & rd_hit;

  ctmr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_hit   (wr_hit),
    .wdata    (bus_wdata),
    .wrap_evt (wrap_evt),
    .tap_evt  (tap_evt),
    .reg_word (reg_word),
    .ovf_flag (ovf_flag),
    .rt_flag  (rt_flag),
    .ovf_en   (ovf_en),
    .rt_en    (rt_en),
    .rt_evt   (rt_evt)
  );

  assign bus_rdata = rd_hit ? reg_word : '0;
  assign irq_ovf   = ovf_flag & ovf_en;
  assign irq_rt    = rt_flag & rt_en;
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_hit,
  input logic [1:0]        clr_bits,
  input logic [7:0]        bus_rdata,
  input logic              irq_ovf,
  input logic              irq_rt,
  input logic              wrap_evt,
  input logic              rt_evt,
  input logic              ovf_flag,
  input logic              rt_flag
);
  logic clr_ovf_wr;
  logic clr_rt_wr;
  assign clr_ovf_wr = wr_hit & clr_bits[1];
  assign clr_rt_wr  = wr_hit & clr_bits[0];

  // R2
  wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);

  // R2
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(wrap_evt));

  // R3
  tap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_evt |=> rt_flag);

  // R5
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf_wr && !wrap_evt) |=> !ovf_flag);

  // R5
  rt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rt_wr && !rt_evt) |=> !rt_flag);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf_wr) |=> ovf_flag);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && clr_ovf_wr) |=> ovf_flag);

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_ADDR) |->
      (irq_ovf == (bus_rdata[7] & bus_rdata[5])) &&
      (irq_rt  == (bus_rdata[6] & bus_rdata[4])));

  // R6
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_ADDR) |-> (bus_rdata[3:2] == 2'b00));

  // R9
  foreign_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00));
endmodule

bind ctmr_core ctmr_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .wr_hit    (wr_hit),
  .clr_bits  (bus_wdata[3:2]),
  .bus_rdata (bus_rdata),
  .irq_ovf   (irq_ovf),
  .irq_rt    (irq_rt),
  .wrap_evt  (wrap_evt),
  .rt_evt    (rt_evt),
  .ovf_flag  (ovf_flag),
  .rt_flag   (rt_flag)
);

// File: tb/tb_ctmr_core.sv
module tb_ctmr_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_ovf;
  logic       irq_rt;

  always #5 clk = ~clk;

  ctmr_core dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_ovf   (irq_ovf),
    .irq_rt    (irq_rt)
  );

  typedef struct {
    logic [7:0] rd;
    logic [7:0] mask;
    logic       io;
    logic       ir;
    string      req;
  } exp_t;

  exp_t  q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // reference counter, equal to the design counter after each edge once locked
  logic [14:0] m_cnt = '0;
  bit          m_on  = 1'b0;
  always @(posedge clk) if (m_on) m_cnt <= m_cnt + 15'd1;

  // monitor: compares queued expectations shortly after each falling edge
  always @(negedge clk) begin
    exp_t e;
    #1;
    while (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if (((rdata & e.mask) !== (e.rd & e.mask)) || irq_ovf !== e.io || irq_rt !== e.ir) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq_ovf=%b irq_rt=%b expected rdata=%h (mask %h) irq_ovf=%b irq_rt=%b",
                 e.req, rdata, irq_ovf, irq_rt, e.rd, e.mask, e.io, e.ir);
      end
    end
  end

  task automatic expect_now(input logic [7:0] rd, input logic [7:0] mask,
                            input logic io, input logic ir, input string req);
    exp_t e;
    e.rd = rd; e.mask = mask; e.io = io; e.ir = ir; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 8'h08; wdata = 8'h00;
  endtask

  task automatic wait_low(input logic [7:0] v);
    @(negedge clk);
    while (m_cnt[7:0] != v) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit locked;
    rst_n = 1'b0; wr = 1'b0; addr = 8'h08; wdata = 8'h00;
    repeat (3) @(negedge clk);
    expect_now(8'h03, 8'hFF, 1'b0, 1'b0, "R7 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_now(8'h03, 8'hFF, 1'b0, 1'b0, "R7 after release");

    // lock the reference counter to the first wrap (R2)
    locked = 1'b0;
    for (int i = 0; i < 600 && !locked; i++) begin
      @(negedge clk);
      #2;
      if (rdata[7]) locked = 1'b1;
    end
    n_cmp++;
    if (!locked) begin
      n_bad++;
      $display("FAIL R2 first wrap: actual=no flag expected=flag within 260 clocks");
    end
    m_cnt = 15'h100;
    m_on  = 1'b1;

    // R5 R6: clear the wrap flag, clear bits read 0
    wr_reg(8'h08, 8'h0B);
    expect_now(8'h03, 8'hFF, 1'b0, 1'b0, "R5 R6 wrap clear");

    // R2: flag absent one clock before wrap, present after
    wait_low(8'hFF);
    expect_now(8'h03, 8'hFF, 1'b0, 1'b0, "R2 before wrap");
    @(negedge clk);
    expect_now(8'h83, 8'hFF, 1'b0, 1'b0, "R2 on wrap");

    // R5: writing the flag positions has no effect
    wait_low(8'h10);
    wr_reg(8'h08, 8'hC3);
    expect_now(8'h83, 8'hFF, 1'b0, 1'b0, "R5 flag bits ignored");
    wr_reg(8'h08, 8'h03);
    expect_now(8'h83, 8'hFF, 1'b0, 1'b0, "R5 zero to flag bits ignored");

    // R4: enable gating of the wrap request
    wr_reg(8'h08, 8'h23);
    expect_now(8'hA3, 8'hFF, 1'b1, 1'b0, "R4 wrap enabled");
    wr_reg(8'h08, 8'h03);
    expect_now(8'h83, 8'hFF, 1'b0, 1'b0, "R4 wrap disabled");

    // R10 R1: enables and rate read back at their positions
    wr_reg(8'h08, 8'h11);
    expect_now(8'h91, 8'hFF, 1'b0, 1'b0, "R10 R1 readback");

    // R9: foreign address write ignored, foreign read is zero
    wr_reg(8'h09, 8'h3E);
    expect_now(8'h91, 8'hFF, 1'b0, 1'b0, "R9 foreign write ignored");
    @(negedge clk);
    addr = 8'h09;
    expect_now(8'h00, 8'hFF, 1'b0, 1'b0, "R9 foreign read");
    @(negedge clk);
    addr = 8'h08;

    // R3: each rate selects its tap bit
    for (int sel = 0; sel < 4; sel++) begin
      int k;
      logic [14:0] pmask;
      logic [14:0] pval;
      k     = 11 + sel;
      pmask = 15'((32'd1 << (k + 1)) - 1);
      pval  = 15'((32'd1 << k) - 1);
      wait_low(8'h20);
      wr_reg(8'h08, 8'h14 | 8'(sel));
      expect_now(8'h10 | 8'(sel), 8'h7F, 1'b0, 1'b0, "R3 tap cleared");
      @(negedge clk);
      while ((m_cnt & pmask) != pval) @(negedge clk);
      expect_now(8'h10 | 8'(sel), 8'h7F, 1'b0, 1'b0, "R3 before tap rise");
      @(negedge clk);
      expect_now(8'h50 | 8'(sel), 8'h7F, 1'b0, 1'b1, "R3 R4 on tap rise");
    end

    // R5: clearing the tap flag keeps the wrap flag
    wait_low(8'h20);
    wr_reg(8'h08, 8'h17);
    expect_now(8'h93, 8'hFF, 1'b0, 1'b0, "R5 tap clear keeps wrap");

    // R8: clear write on the wrap edge loses to the set
    wait_low(8'hFE);
    wr_reg(8'h08, 8'h0B);
    expect_now(8'h83, 8'hFF, 1'b0, 1'b0, "R8 set wins");
    wait_low(8'h20);
    wr_reg(8'h08, 8'h0B);
    expect_now(8'h03, 8'hFF, 1'b0, 1'b0, "R5 clear away from wrap");

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule